// File: doc/BRIEF.md
# ALU with Condition Codes

This block is the arithmetic and logic unit of a small load/store RISC core. It takes two 32-bit operands, an operation code and a set-codes strobe. It produces a 32-bit result in the same cycle. A four-bit flag register holds negative, zero, overflow and carry. The flag register changes only on a rising clock edge, and only when the set-codes strobe is high for an arithmetic or bitwise-logic operation.

The unit supports add, subtract, AND, OR, NOR, XOR, three shifts and an upper-immediate placement. A shift takes its amount either from an instruction immediate or from the low five bits of the second operand. The placement operation puts a 22-bit value into the top of the word. The core's decoder drives the operation code, and the register file supplies the operands. Neither of those is part of this block.

Top module: `alu_cc`

## Requirements
- R1: While the active-low reset is asserted, and after it is released, the flags N, Z, V and C all read 0 until the first code-setting operation.
- R2: Operation code 0 (add) gives opA+opB modulo 2^32. Code 1 (subtract) gives opA-opB modulo 2^32.
- R3: An add with setCodes high loads the flags on the next rising edge. N is result bit 31, Z is set when the result is zero, C is the carry out of bit 31, and V is set when the operands have equal signs and the result sign differs from them.
- R4: A subtract with setCodes high loads all four flags. C is set when a borrow occurs (opA below opB, unsigned). V is set when the operand signs differ and the result sign differs from opA. N and Z follow the result.
- R5: Codes 2, 3, 4 and 5 give AND, OR, NOR and XOR of the operands. NOR with a zero opB gives the complement of opA.
- R6: A logic operation (codes 2 to 5) with setCodes high loads N and Z from the result and leaves V and C at their previous values.
- R7: Code 6 shifts opA right and fills with zeros. Code 7 shifts opA left and fills with zeros. Code 8 shifts opA right and copies bit 31 into the vacated bits. Amounts 0 to 31 are all supported.
- R8: The shift amount is shiftImm when useImm is 1. Otherwise it is opB[4:0], and opB[31:5] have no effect.
- R9: Code 9 outputs {highImm, 10'b0}. opA and opB have no effect on this result.
- R10: When setCodes is low, the flags keep their values across the clock edge. A shift (codes 6 to 8) or a placement (code 9) never changes the flags, even with setCodes high.
- R11: Codes 10 to 15 output zero and never change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Active-low asynchronous reset of the flags |
| opA | input | 32 | First operand; also the value that is shifted |
| opB | input | 32 | Second operand; its low 5 bits can set the shift amount |
| opSel | input | 4 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 nor, 5 xor, 6 srl, 7 sll, 8 sra, 9 high) |
| setCodes | input | 1 | Request a flag update at the next rising edge |
| useImm | input | 1 | Take the shift amount from shiftImm rather than opB |
| shiftImm | input | 5 | Immediate shift amount |
| highImm | input | 22 | Value placed in bits 31:10 by the high operation |
| result | output | 32 | Combinational result |
| flagN | output | 1 | Registered negative flag |
| flagZ | output | 1 | Registered zero flag |
| flagV | output | 1 | Registered signed-overflow flag |
| flagC | output | 1 | Registered carry/borrow flag |

## Verification
The bench checks the carry and borrow senses at their edges: an add that wraps to zero, a subtract of a larger value from a smaller one, and a subtract of equal values. A unit that used the raw adder carry for subtract would report C inverted on these cases. Signed overflow is driven both ways, and a wrong sign comparison would mark the largest positive plus one as clean. A logic operation is run right after an arithmetic one has set V and C, so a design that cleared or reloaded those two flags would be caught. The bench also checks shift amounts of 0 and 31, an arithmetic shift of negative values, and opB values whose upper bits are set while the amount comes from opB. A design that used those upper bits, or filled with the wrong bit, gives a different result.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_XOR  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRA  = 4'd8,
    OP_HIGH = 4'd9
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2,
    LG_XOR = 2'd3
  } logicFn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef struct packed {
    logic     arithEn;
    logic     isSub;
    logic     logicEn;
    logicFn_e logicFn;
    logic     shiftEn;
    logic     shLeft;
    logic     shArith;
    logic     highEn;
    logic     wrNZ;
    logic     wrVC;
  } strobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic       setCodes,
  output strobe_t    strobe
);

  always_comb begin
    strobe = '0;
    strobe.logicFn = LG_AND;
    case (opSel)
      OP_ADD: strobe.arithEn = 1'b1;
      OP_SUB: begin
        strobe.arithEn = 1'b1;
        strobe.isSub   = 1'b1;
      end
      OP_AND: begin
        strobe.logicEn = 1'b1;
        strobe.logicFn = LG_AND;
      end
      OP_OR: begin
        strobe.logicEn = 1'b1;
        strobe.logicFn = LG_OR;
      end
      OP_NOR: begin
        strobe.logicEn = 1'b1;
        strobe.logicFn = LG_NOR;
      end
      OP_XOR: begin
        strobe.logicEn = 1'b1;
        strobe.logicFn = LG_XOR;
      end
      OP_SRL: strobe.shiftEn = 1'b1;
      OP_SLL: begin
        strobe.shiftEn = 1'b1;
        strobe.shLeft  = 1'b1;
      end
      OP_SRA: begin
        strobe.shiftEn = 1'b1;
        strobe.shArith = 1'b1;
      end
      OP_HIGH: strobe.highEn = 1'b1;
      default: ;
    endcase
    strobe.wrNZ = setCodes & (strobe.arithEn | strobe.logicEn);
    strobe.wrVC = setCodes & strobe.arithEn;
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HIGH_W = 22
) (
  input  strobe_t                     strobe,
  input  logic [DATA_W-1:0]           opA,
  input  logic [DATA_W-1:0]           opB,
  input  logic                        useImm,
  input  logic [$clog2(DATA_W)-1:0]   shiftImm,
  input  logic [HIGH_W-1:0]           highImm,
  output logic [DATA_W-1:0]           result,
  output flags_t                      flagsNext
);

  localparam int SH_W  = $clog2(DATA_W);
  localparam int LOW_W = DATA_W - HIGH_W;

  // adder / subtractor
  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sumVal;
  logic              carryOut;
  logic              arithV;
  logic              arithC;

  assign bEff     = strobe.isSub ? ~opB : opB;
  assign sumWide  = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, strobe.isSub};
  assign sumVal   = sumWide[DATA_W-1:0];
  assign carryOut = sumWide[DATA_W];
  assign arithC   = strobe.isSub ? ~carryOut : carryOut;
  assign arithV   = (opA[DATA_W-1] == bEff[DATA_W-1]) &&
                    (sumVal[DATA_W-1] != opA[DATA_W-1]);

  // bitwise logic
  logic [DATA_W-1:0] logicVal;
  always_comb begin
    case (strobe.logicFn)
      LG_AND:  logicVal = opA & opB;
      LG_OR:   logicVal = opA | opB;
      LG_NOR:  logicVal = ~(opA | opB);
      default: logicVal = opA ^ opB;
    endcase
  end

  // barrel shifter: one right-shift core, left shifts by bit reversal
  logic [SH_W-1:0]   shAmt;
  logic              fillBit;
  logic [DATA_W-1:0] shIn;
  logic [DATA_W-1:0] shCore;
  logic [DATA_W-1:0] shiftVal;
  logic [DATA_W-1:0] stage [0:SH_W];

  assign shAmt   = useImm ? shiftImm : opB[SH_W-1:0];
  assign fillBit = strobe.shArith & opA[DATA_W-1];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      shIn[i] = strobe.shLeft ? opA[DATA_W-1-i] : opA[i];
    end
  end

  assign stage[0] = shIn;

  for (genvar s = 0; s < SH_W; s++) begin : g_shStage
    localparam int STEP = 1 << s;
    assign stage[s+1] = shAmt[s] ? {{STEP{fillBit}}, stage[s][DATA_W-1:STEP]}
                                 : stage[s];
  end

  assign shCore = stage[SH_W];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      shiftVal[i] = strobe.shLeft ? shCore[DATA_W-1-i] : shCore[i];
    end
  end

  // result select
  always_comb begin
    if (strobe.arithEn)      result = sumVal;
    else if (strobe.logicEn) result = logicVal;
    else if (strobe.shiftEn) result = shiftVal;
    else if (strobe.highEn)  result = {highImm, {LOW_W{1'b0}}};
    else                     result = '0;
  end

  assign flagsNext.n = result[DATA_W-1];
  assign flagsNext.z = (result == '0);
  assign flagsNext.v = arithV;
  assign flagsNext.c = arithC;

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrNZ,
  input  logic   wrVC,
  input  flags_t flagsNext,
  output flags_t flagsQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else begin
      if (wrNZ) begin
        flagsQ.n <= flagsNext.n;
        flagsQ.z <= flagsNext.z;
      end
      if (wrVC) begin
        flagsQ.v <= flagsNext.v;
        flagsQ.c <= flagsNext.c;
      end
    end
  end

endmodule

// File: rtl/alu_cc.sv
module alu_cc
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HIGH_W = 22
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DATA_W-1:0]         opA,
  input  logic [DATA_W-1:0]         opB,
  input  logic [3:0]                opSel,
  input  logic                      setCodes,
  input  logic                      useImm,
  input  logic [$clog2(DATA_W)-1:0] shiftImm,
  input  logic [HIGH_W-1:0]         highImm,
  output logic [DATA_W-1:0]         result,
  output logic                      flagN,
  output logic                      flagZ,
  output logic                      flagV,
  output logic                      flagC
);

  strobe_t strobe;
  flags_t  flagsNext;
  flags_t  flagsQ;

  alu_ctrl u_ctrl (
    .opSel    (opSel),
    .setCodes (setCodes),
    .strobe   (strobe)
  );

  alu_datapath #(
    .DATA_W (DATA_W),
    .HIGH_W (HIGH_W)
  ) u_datapath (
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .useImm    (useImm),
    .shiftImm  (shiftImm),
    .highImm   (highImm),
    .result    (result),
    .flagsNext (flagsNext)
  );

  alu_flag_reg u_flags (
    .clk       (clk),
    .rstN      (rstN),
    .wrNZ      (strobe.wrNZ),
    .wrVC      (strobe.wrVC),
    .flagsNext (flagsNext),
    .flagsQ    (flagsQ)
  );

  assign flagN = flagsQ.n;
  assign flagZ = flagsQ.z;
  assign flagV = flagsQ.v;
  assign flagC = flagsQ.c;

endmodule

// File: rtl/alu_cc_chk.sv
module alu_cc_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  opSel,
  input logic        setCodes,
  input logic [21:0] highImm,
  input logic [31:0] result,
  input logic        flagN,
  input logic        flagZ,
  input logic        flagV,
  input logic        flagC
);

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !setCodes |=> $stable({flagN, flagZ, flagV, flagC}));

  // R10
  shift_high_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel >= 4'd6) |=> $stable({flagN, flagZ, flagV, flagC}));

  // R6
  logic_keep_vc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setCodes && opSel >= 4'd2 && opSel <= 4'd5) |=> $stable({flagV, flagC}));

  // R3
  arith_nz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setCodes && opSel <= 4'd1) |=>
      (flagZ == ($past(result) == 32'd0)) && (flagN == $past(result[31])));

  // R9
  high_place_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 4'd9) |-> (result == {highImm, 10'd0}));

  // R11
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel >= 4'd10) |-> (result == 32'd0));

endmodule

bind alu_cc alu_cc_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opSel    (opSel),
  .setCodes (setCodes),
  .highImm  (highImm),
  .result   (result),
  .flagN    (flagN),
  .flagZ    (flagZ),
  .flagV    (flagV),
  .flagC    (flagC)
);

// File: tb/alu_cc_tb.sv
`timescale 1ns/100ps
module alu_cc_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  opSel = '0;
  logic        setCodes = 1'b0;
  logic        useImm = 1'b0;
  logic [4:0]  shiftImm = '0;
  logic [21:0] highImm = '0;
  logic [31:0] result;
  logic        flagN, flagZ, flagV, flagC;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [3:0] mFlags = 4'b0000; // {N,Z,V,C}

  always #2.5 clk = ~clk;

  alu_cc u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .setCodes(setCodes), .useImm(useImm), .shiftImm(shiftImm),
    .highImm(highImm), .result(result),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  function automatic logic [31:0] expRes(logic [3:0] op, logic [31:0] a,
      logic [31:0] b, logic ui, logic [4:0] imm, logic [21:0] hi);
    logic [4:0] amt;
    amt = ui ? imm : b[4:0];
    case (op)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return ~(a | b);
      4'd5: return a ^ b;
      4'd6: return a >> amt;
      4'd7: return a << amt;
      4'd8: return $unsigned($signed(a) >>> amt);
      4'd9: return {hi, 10'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [3:0] expFlags(logic [3:0] op, logic [31:0] a,
      logic [31:0] b, logic sc, logic [31:0] r, logic [3:0] prev);
    logic [3:0] f;
    logic [32:0] w;
    f = prev;
    if (sc && op <= 4'd5) begin
      f[3] = r[31];
      f[2] = (r == 32'd0);
      if (op == 4'd0) begin
        w = {1'b0, a} + {1'b0, b};
        f[0] = w[32];
        f[1] = (a[31] == b[31]) && (r[31] != a[31]);
      end else if (op == 4'd1) begin
        f[0] = (a < b);
        f[1] = (a[31] != b[31]) && (r[31] != a[31]);
      end
    end
    return f;
  endfunction

  function automatic string tagOf(logic [3:0] op, logic ui);
    if (op <= 4'd1) return "R2";
    if (op <= 4'd5) return "R5";
    if (op <= 4'd8) return ui ? "R7" : "R8";
    if (op == 4'd9) return "R9";
    return "R11";
  endfunction

  function automatic string ftagOf(logic [3:0] op, logic sc);
    if (!sc) return "R10";
    if (op == 4'd0) return "R3";
    if (op == 4'd1) return "R4";
    if (op <= 4'd5) return "R6";
    if (op <= 4'd9) return "R10";
    return "R11";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doOp(logic [3:0] op, logic [31:0] a, logic [31:0] b,
      logic sc, logic ui, logic [4:0] imm, logic [21:0] hi);
    logic [31:0] r;
    @(negedge clk);
    opSel = op; opA = a; opB = b; setCodes = sc;
    useImm = ui; shiftImm = imm; highImm = hi;
    r = expRes(op, a, b, ui, imm, hi);
    #1;
    check(tagOf(op, ui), result, r);
    mFlags = expFlags(op, a, b, sc, r, mFlags);
    @(posedge clk);
    #1;
    check(ftagOf(op, sc), {28'd0, flagN, flagZ, flagV, flagC}, {28'd0, mFlags});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired before the run completed");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {28'd0, flagN, flagZ, flagV, flagC}, 32'd0); // R1 in reset
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1", {28'd0, flagN, flagZ, flagV, flagC}, 32'd0); // R1 after release

    // R3: signed overflow into negative, no carry
    doOp(4'd0, 32'h7fff_ffff, 32'd1, 1'b1, 1'b0, 5'd0, 22'd0);
    // R3: wrap to zero with carry
    doOp(4'd0, 32'hffff_ffff, 32'd1, 1'b1, 1'b0, 5'd0, 22'd0);
    // R6: logic keeps V,C set by the arithmetic op
    doOp(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 5'd0, 22'd0);
    doOp(4'd3, 32'h0000_0010, 32'h0000_0001, 1'b1, 1'b0, 5'd0, 22'd0);
    // R4: borrow and equal operands
    doOp(4'd1, 32'd1, 32'd2, 1'b1, 1'b0, 5'd0, 22'd0);
    doOp(4'd1, 32'd5, 32'd5, 1'b1, 1'b0, 5'd0, 22'd0);
    // R4: signed overflow on subtract
    doOp(4'd1, 32'h8000_0000, 32'd1, 1'b1, 1'b0, 5'd0, 22'd0);
    // R5: NOR with zero complements
    doOp(4'd4, 32'h1234_5678, 32'd0, 1'b1, 1'b0, 5'd0, 22'd0);
    // R10: no setCodes, flags held
    doOp(4'd1, 32'd0, 32'd0, 1'b0, 1'b0, 5'd0, 22'd0);
    // R10: shift with setCodes leaves flags
    doOp(4'd6, 32'd0, 32'd0, 1'b1, 1'b1, 5'd0, 22'd0);
    // R7: boundary amounts and sign fill
    doOp(4'd8, 32'h8000_0000, 32'd0, 1'b0, 1'b1, 5'd31, 22'd0);
    doOp(4'd8, 32'hf000_00f0, 32'd0, 1'b0, 1'b1, 5'd4, 22'd0);
    doOp(4'd7, 32'h0000_0001, 32'd0, 1'b0, 1'b1, 5'd31, 22'd0);
    doOp(4'd6, 32'hdead_beef, 32'd0, 1'b0, 1'b1, 5'd0, 22'd0);
    // R8: amount from opB with upper bits set
    doOp(4'd6, 32'hffff_ffff, 32'hffff_ffe3, 1'b0, 1'b0, 5'd17, 22'd0);
    doOp(4'd7, 32'h0000_00ff, 32'h1234_5680, 1'b0, 1'b0, 5'd9, 22'd0);
    // R9: placement ignores operands
    doOp(4'd9, 32'hffff_ffff, 32'hffff_ffff, 1'b1, 1'b0, 5'd0, 22'h304f15);
    // R11: undefined codes
    doOp(4'd12, 32'h1111_1111, 32'h2222_2222, 1'b1, 1'b0, 5'd0, 22'h3fffff);

    for (int i = 0; i < 400; i++) begin
      doOp(4'($urandom_range(0, 15)), $urandom, $urandom, 1'($urandom),
           1'($urandom), 5'($urandom), 22'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule